// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Sequencer

This block sits between a synchronous requester and an external asynchronous static RAM that holds 16-bit words at 16-bit addresses and has two active-low byte-lane enables. The requester offers one read or write at a time with a valid/ready handshake. Each request carries an address, write data and a two-bit lane mask. The block turns every accepted request into a complete memory cycle on the RAM pins, and returns read data with a one-clock valid strobe.

Each pin is driven from a register. Every phase of a cycle lasts a whole number of clocks, and parameters set these counts: the read wait, the write-enable low width, the turnaround after a read and the idle time after a write. Between requests the chip enable stays high, which keeps the RAM in standby. The data bus is split into an output, an input and a driver enable for the pad tristate. The controller never turns on its drivers while the RAM's outputs could be on. After a write it also keeps address and data stable through the clock in which write enable returns high.

Top module: `sram_bus_ctrl`

## Requirements
- R1: Out of reset, and whenever no request is in progress, ready is high, chip enable (active low) is high, write enable and output enable are high, both lane enables are high and the data driver enable is low.
- R2: A request is taken only on a clock edge where req_valid and ready are both high. Ready goes low at that edge and stays low until the last recovery clock of the cycle ends. A request held valid while ready is low is neither lost nor taken twice.
- R3: A write with a nonzero mask runs as follows, with chip enable low throughout: one setup clock with write enable high and the data drivers on, then WE_LOW_CLKS clocks with write enable low, then one hold clock with write enable high and the drivers still on. Output enable stays high for the whole write.
- R4: The data driver enable is never high while output enable is low.
- R5: A read with a nonzero mask holds chip enable and output enable low and write enable high for RD_WAIT_CLKS clocks, with the data drivers off.
- R6: Lane-enable bit 0 gates data bits 7..0 and bit 1 gates bits 15..8. A lane enable is driven low for the whole active cycle exactly when the matching mask bit (bit 0 for the low byte, bit 1 for the high byte) is 1. Only those lanes are changed in memory.
- R7: Read data is taken from the data-in bus at the edge that ends the last wait clock. It is shown on rd_data with rd_valid high for exactly one clock: the first clock after output enable is released. Lanes whose mask bit is 0 read as zero.
- R8: After the hold clock of a write, chip enable and write enable are high and the drivers are off for WR_IDLE_CLKS clocks (at least one) before ready returns.
- R9: After a read, output enable and chip enable are high and the drivers are off for RD_TURN_CLKS clocks before ready returns.
- R10: A request with mask 0 drives no strobes: chip enable stays high. It completes in one clock with ready low. A zero-mask write leaves memory unchanged, and a zero-mask read gives an rd_valid pulse with rd_data equal to 0 in that clock.
- R11: Throughout a write, the address and the data output stay at the accepted request's values, including in the clock where write enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rd_valid | output | 1 | One-clock read result strobe |
| rd_data | output | 16 | Read result, unselected lanes zero |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Lane enables, active low |
| sram_addr | output | 16 | Memory address |
| sram_dq_out | output | 16 | Data toward memory |
| sram_dq_in | input | 16 | Data from memory |
| sram_dq_oe | output | 1 | Data driver enable for the pad tristate |

## Verification
Some pin rules are checked on every cycle by the assertions. The drivers are never on while output enable is low. Write enable is low only with chip enable low, output enable high and the drivers on. Address and data are stable in the clock where write enable rises. Ready implies standby. Read valid never lasts two clocks. Only the bench's scenarios can show the rest, because it depends on a memory: the exact phase lengths, lane-selective merging, zeroing of unread lanes, zero-mask no-ops, and requests held through a busy period. The bench checks these by comparing the pins cycle by cycle against a queue of expected states and reading written data back through a behavioural RAM.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_SET,
    ST_WR_PUL,
    ST_WR_HLD,
    ST_RECOV
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT_CLKS = 2,
  parameter int WE_LOW_CLKS  = 2,
  parameter int RD_TURN_CLKS = 1,
  parameter int WR_IDLE_CLKS = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     req_valid,
  input  logic     req_write,
  input  logic     mask_any,
  output logic     ready,
  output logic     accept,
  output logic     cap,
  output logic     nop_rd,
  output pin_ctl_t ctl_nxt
);

  localparam int M1      = (RD_WAIT_CLKS > WE_LOW_CLKS) ? RD_WAIT_CLKS : WE_LOW_CLKS;
  localparam int M2      = (RD_TURN_CLKS > WR_IDLE_CLKS) ? RD_TURN_CLKS : WR_IDLE_CLKS;
  localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_t       st, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt     = st;
    cnt_nxt = cnt;
    accept  = 1'b0;
    cap     = 1'b0;
    nop_rd  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (!mask_any) begin
            nxt     = ST_RECOV;
            cnt_nxt = '0;
            nop_rd  = !req_write;
          end else if (req_write) begin
            nxt     = ST_WR_SET;
            cnt_nxt = '0;
          end else begin
            nxt     = ST_RD_ACC;
            cnt_nxt = CNT_W'(RD_WAIT_CLKS - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (cnt == '0) begin
          cap     = 1'b1;
          nxt     = ST_RECOV;
          cnt_nxt = CNT_W'(RD_TURN_CLKS - 1);
        end else begin
          cnt_nxt = cnt - 1'b1;
        end
      end
      ST_WR_SET: begin
        nxt     = ST_WR_PUL;
        cnt_nxt = CNT_W'(WE_LOW_CLKS - 1);
      end
      ST_WR_PUL: begin
        if (cnt == '0) nxt = ST_WR_HLD;
        else           cnt_nxt = cnt - 1'b1;
      end
      ST_WR_HLD: begin
        nxt     = ST_RECOV;
        cnt_nxt = CNT_W'(WR_IDLE_CLKS - 1);
      end
      ST_RECOV: begin
        if (cnt == '0) nxt = ST_IDLE;
        else           cnt_nxt = cnt - 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      ST_RD_ACC: ctl_nxt = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      ST_WR_SET: ctl_nxt = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WR_PUL: ctl_nxt = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WR_HLD: ctl_nxt = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      default:   ctl_nxt = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      ready <= 1'b1;
    end else begin
      st    <= nxt;
      cnt   <= cnt_nxt;
      ready <= (nxt == ST_IDLE);
    end
  end

  // R2
  busy_blocks_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !accept);

endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  pin_ctl_t          ctl_nxt,
  output logic [LANES-1:0]  lane_sel,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic [LANES-1:0]  be_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out
);

  logic [LANES-1:0] lane_src;
  assign lane_src = accept ? req_mask : lane_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      dq_oe    <= 1'b0;
      be_n     <= '1;
      lane_sel <= '0;
      addr     <= '0;
      dq_out   <= '0;
    end else begin
      ce_n  <= ctl_nxt.ce_n;
      we_n  <= ctl_nxt.we_n;
      oe_n  <= ctl_nxt.oe_n;
      dq_oe <= ctl_nxt.dq_oe;
      be_n  <= ctl_nxt.ce_n ? '1 : ~lane_src;
      if (accept) begin
        lane_sel <= req_mask;
        addr     <= req_addr;
        dq_out   <= req_wdata;
      end
    end
  end

  // R4
  no_drive_while_oe_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  // R3
  we_low_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && oe_n && dq_oe));

  // R11
  we_rise_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && $rose(we_n)) |-> ($stable(addr) && $stable(dq_out) && dq_oe));

  // R9
  oe_release_turn_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n) |-> (!dq_oe && ce_n));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              nop_rd,
  input  logic [LANES-1:0]  lane_sel,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] keep;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign keep[g*8 +: 8] = {8{lane_sel[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap | nop_rd;
      if (cap)         rd_data <= dq_in & keep;
      else if (nop_rd) rd_data <= '0;
    end
  end

  // R7
  rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int RD_WAIT_CLKS = 2,
  parameter int WE_LOW_CLKS  = 2,
  parameter int RD_TURN_CLKS = 1,
  parameter int WR_IDLE_CLKS = 1,
  localparam int LANES       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [LANES-1:0]  sram_be_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  logic             accept, cap, nop_rd;
  pin_ctl_t         ctl_nxt;
  logic [LANES-1:0] lane_sel;

  sram_seq_fsm #(
    .RD_WAIT_CLKS(RD_WAIT_CLKS),
    .WE_LOW_CLKS (WE_LOW_CLKS),
    .RD_TURN_CLKS(RD_TURN_CLKS),
    .WR_IDLE_CLKS(WR_IDLE_CLKS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .mask_any (|req_mask),
    .ready    (req_ready),
    .accept   (accept),
    .cap      (cap),
    .nop_rd   (nop_rd),
    .ctl_nxt  (ctl_nxt)
  );

  sram_pin_reg #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_mask (req_mask),
    .ctl_nxt  (ctl_nxt),
    .lane_sel (lane_sel),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe),
    .be_n     (sram_be_n),
    .addr     (sram_addr),
    .dq_out   (sram_dq_out)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .nop_rd  (nop_rd),
    .lane_sel(lane_sel),
    .dq_in   (sram_dq_in),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  // R1
  ready_means_standby_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  // R8
  drv_off_recovery_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_dq_oe) |-> (sram_ce_n && sram_we_n && !req_ready));

endmodule

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;

  localparam int RDW = 2, WEL = 2, RDT = 1, WRI = 1;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rd_valid, ce_n, we_n, oe_n, dq_oe;
  logic [15:0] rd_data, s_addr, dq_out, dq_in = '0;
  logic [1:0]  be_n;

  sram_bus_ctrl #(.RD_WAIT_CLKS(RDW), .WE_LOW_CLKS(WEL),
                  .RD_TURN_CLKS(RDT), .WR_IDLE_CLKS(WRI)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_ce_n(ce_n), .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_be_n(be_n),
    .sram_addr(s_addr), .sram_dq_out(dq_out), .sram_dq_in(dq_in),
    .sram_dq_oe(dq_oe));

  always #5 clk = ~clk;

  typedef struct {
    bit        ce_n, we_n, oe_n, dq_oe, ready, rv;
    bit [1:0]  be_n;
    bit [15:0] rdat, addr, dout;
    bit        chk_bus, chk_dout;
    string     tag;
  } exp_t;

  exp_t        q[$];
  logic [15:0] ram[int];
  logic [15:0] shadow[int];
  int          tests = 0, fails = 0, cycles = 0;
  bit          checking = 1'b0;
  logic        prev_we = 1'b1;

  function automatic logic [15:0] lanes(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // behavioural RAM: drives data when selected, junk otherwise; commits on WE rise
  always @(negedge clk) begin
    logic [15:0] v;
    v = ram.exists(int'(s_addr)) ? ram[int'(s_addr)] : 16'h0000;
    if (!ce_n && !oe_n && we_n)
      dq_in = (v & ~{{8{be_n[1]}}, {8{be_n[0]}}}) | (16'hA5A5 & {{8{be_n[1]}}, {8{be_n[0]}}});
    else
      dq_in = 16'h5A5A;
    if (!rst && !prev_we && we_n && !ce_n) begin
      if (!be_n[0]) v[7:0]  = dq_out[7:0];
      if (!be_n[1]) v[15:8] = dq_out[15:8];
      ram[int'(s_addr)] = v;
    end
    prev_we = we_n;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t idle_item(input string tag, input bit rdy);
    exp_t e;
    e.ce_n = 1; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0; e.be_n = 2'b11;
    e.ready = rdy; e.rv = 0; e.rdat = 0; e.addr = 0; e.dout = 0;
    e.chk_bus = 0; e.chk_dout = 0; e.tag = tag;
    return e;
  endfunction

  task automatic push_expect(input bit w, input logic [15:0] a,
                             input logic [15:0] d, input logic [1:0] m);
    exp_t e;
    logic [15:0] sv;
    sv = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (m == 2'b00) begin
      e = idle_item("R10", 0);
      e.rv = !w;
      q.push_back(e);
    end else if (!w) begin
      for (int i = 0; i < RDW; i++) begin
        e = idle_item("R5", 0);
        e.ce_n = 0; e.oe_n = 0; e.be_n = ~m; e.addr = a; e.chk_bus = 1;
        q.push_back(e);
      end
      for (int i = 0; i < RDT; i++) begin
        e = idle_item(i == 0 ? "R7" : "R9", 0);
        e.rv = (i == 0); e.rdat = sv & lanes(m);
        q.push_back(e);
      end
    end else begin
      e = idle_item("R3", 0);
      e.ce_n = 0; e.dq_oe = 1; e.be_n = ~m; e.addr = a; e.dout = d;
      e.chk_bus = 1; e.chk_dout = 1;
      q.push_back(e);
      e.we_n = 0; e.tag = "R11";
      for (int i = 0; i < WEL; i++) q.push_back(e);
      e.we_n = 1; e.tag = "R11";
      q.push_back(e);
      for (int i = 0; i < WRI; i++) q.push_back(idle_item("R8", 0));
      shadow[int'(a)] = (sv & ~lanes(m)) | (d & lanes(m));
    end
  endtask

  // cycle-by-cycle comparison against the expected queue
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (checking) begin
      e = (q.size() > 0) ? q.pop_front() : idle_item("R1", 1);
      chk({ce_n, we_n, oe_n, dq_oe} == {e.ce_n, e.we_n, e.oe_n, e.dq_oe},
          e.tag, "ce/we/oe/drv", int'({ce_n, we_n, oe_n, dq_oe}),
          int'({e.ce_n, e.we_n, e.oe_n, e.dq_oe}));
      chk(be_n == e.be_n, e.tag == "R1" ? "R1" : "R6", "lane enables",
          int'(be_n), int'(e.be_n));
      chk(req_ready == e.ready, e.ready ? "R1" : "R2", "ready",
          int'(req_ready), int'(e.ready));
      chk(rd_valid == e.rv, e.tag == "R10" ? "R10" : "R7", "rd_valid",
          int'(rd_valid), int'(e.rv));
      if (e.rv)
        chk(rd_data == e.rdat, e.tag, "rd_data", int'(rd_data), int'(e.rdat));
      if (e.chk_bus)
        chk(s_addr == e.addr, "R11", "address", int'(s_addr), int'(e.addr));
      if (e.chk_dout)
        chk(dq_out == e.dout, "R11", "write data", int'(dq_out), int'(e.dout));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // present a request; it is pushed to the model on the negedge before the accepting edge
  task automatic issue(input bit w, input logic [15:0] a,
                       input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    push_expect(w, a, d, m);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    checking = 1;
    // R1 reset and standby
    repeat (3) @(negedge clk);
    // R3 R5 R6 R7 full-word write and read, boundary addresses
    issue(1, 16'h0000, 16'hBEEF, 2'b11);
    issue(0, 16'h0000, 16'h0000, 2'b11);
    issue(1, 16'hFFFF, 16'h1234, 2'b11);
    issue(0, 16'hFFFF, 16'h0000, 2'b11);
    // R6 low-lane then high-lane merge
    issue(1, 16'h0040, 16'hAAAA, 2'b11);
    issue(1, 16'h0040, 16'h1155, 2'b01);
    issue(0, 16'h0040, 16'h0000, 2'b11);
    issue(1, 16'h0040, 16'h66FF, 2'b10);
    issue(0, 16'h0040, 16'h0000, 2'b11);
    // R7 partial reads return zero in unselected lanes
    issue(0, 16'h0040, 16'h0000, 2'b01);
    issue(0, 16'h0040, 16'h0000, 2'b10);
    // R10 zero-mask write leaves memory, zero-mask read returns 0
    issue(1, 16'h0040, 16'h0000, 2'b00);
    issue(0, 16'h0040, 16'h0000, 2'b00);
    issue(0, 16'h0040, 16'h0000, 2'b11);
    // R2 held request with back-to-back issue, drain after each is idle-checked
    drain();
    // R8 R9 mixed random traffic
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = {12'h000, 4'($urandom_range(0, 15))};
      issue(1'($urandom_range(0, 1)), a, 16'($urandom()), 2'($urandom_range(0, 3)));
    end
    drain();
    for (int i = 0; i < 16; i++) issue(0, 16'(i), 16'h0000, 2'b11);
    drain();
    repeat (2) @(negedge clk);
    checking = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule